// File: doc/BRIEF.md
# Transfer Controller Activation Vector Unit

This block sits in front of a small data-transfer engine and decides when the engine starts and where its descriptor lives. Peripheral interrupt requests arrive as a level vector. Each source has a bit in an enable vector. A source whose enable bit is set goes to the transfer path. A source whose enable bit is clear goes to the CPU interrupt controller. A software-activation register holds a 7-bit vector number and a request bit. Software activation ranks below every hardware source.

When the unit is idle it picks one pending activation and forms a 16-bit vector-table address. It reads the 16-bit table entry through a request/ready memory port and checks that the entry is 4-byte aligned. If it is, the unit starts the engine at the full descriptor address: a fixed on-chip RAM prefix joined to the entry. When the engine reports that it has finished, the unit issues a one-cycle clear. The clear goes either to the source's interrupt flag or to its enable bit, as the per-source clear selection chooses. Only one activation is in flight at a time. Any other request stays pending until the unit is idle again.

Top module: `xfer_vector_unit`

## Requirements
- R1: The routing of a request does not depend on any CPU mask or priority. One cycle after a request is seen, `cpu_irq[n]` is high exactly when `src_req[n]` is high and `src_en[n]` is low. An enabled source never appears on `cpu_irq`.
- R2: When several activations are pending in the idle state, the lowest hardware source index is fetched first. Software activation is taken only when no enabled hardware source is pending.
- R3: Hardware source n reads its vector entry at address 0x0400 + 2n.
- R4: Software activation reads its entry at 0x0400 + (vector number << 1). Vector number 0x10 reads 0x0420 and vector number 0x7F reads 0x04FE.
- R5: `mem_req` stays high with a stable `mem_addr` until `mem_ready` is sampled high. In the cycle after that, `mem_req` is low. At most one read is outstanding.
- R6: In the cycle after a ready read whose data has bits [1:0] = 00, `eng_start` pulses for one cycle. In that cycle `eng_addr` equals `{RAM_PREFIX, data}`, with a default prefix of 0xFF and a 24-bit address.
- R7: In the cycle after a ready read whose data has bits [1:0] other than 00, `align_err` pulses for one cycle. No `eng_start` and no clear follow, and the unit returns to idle.
- R8: In the cycle after `eng_done` is sampled for hardware source n, exactly one of two one-cycle pulses is issued. `flag_clr[n]` pulses when `clr_sel[n]` = 0, and `en_clr[n]` pulses when `clr_sel[n]` = 1. A software activation issues neither.
- R9: `sw_pending` follows a `sw_wr` write of `sw_wr_req`. It falls in the cycle after the ready read of its own vector entry, and a write in that same cycle takes precedence.
- R10: Requests that arrive while an activation is in flight are not lost. They are served in priority order after the unit returns to idle.
- R11: While `rst_n` is low and after reset, all pulse outputs, `mem_req`, `cpu_irq` and `sw_pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Peripheral interrupt request levels |
| src_en | input | NUM_SRC | Per-source transfer enable |
| clr_sel | input | NUM_SRC | Per-source clear target: 0 = source flag, 1 = enable bit |
| sw_wr | input | 1 | Write strobe of the software-activation register |
| sw_wr_vec | input | 7 | Vector number to write |
| sw_wr_req | input | 1 | Request bit to write |
| sw_pending | output | 1 | Current software request bit |
| cpu_irq | output | NUM_SRC | Requests forwarded to the CPU interrupt controller |
| mem_req | output | 1 | Vector-table read request |
| mem_addr | output | 16 | Vector-table read address |
| mem_ready | input | 1 | Read data valid and request accepted |
| mem_rdata | input | 16 | Vector-table entry |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_addr | output | ADDR_W | Full descriptor start address |
| eng_done | input | 1 | Transfer engine has finished the transfer |
| align_err | output | 1 | One-cycle pulse for a misaligned table entry |
| flag_clr | output | NUM_SRC | One-cycle source-flag clear |
| en_clr | output | NUM_SRC | One-cycle enable-bit clear |

## Verification
The assertions take for granted that the memory side asserts `mem_ready` only while `mem_req` is high. They also assume that `eng_done` arrives only while an engine run is outstanding, and that requests are levels which the outside clears only through `flag_clr`. The bench keeps to these assumptions. Its memory and engine responders answer only what the unit has asked for. Its peripheral model sets flags with single-cycle pulses and clears them only on `flag_clr`, and the enable register drops bits only on `en_clr` or a full reload from the stimulus.

// File: rtl/xvu_pkg.sv
// Shared types for the transfer activation vector unit.
// Assumes nothing beyond a 16-bit vector-table address space.
package xvu_pkg;

    // Sequencer states: idle, table read, start/error, engine run, clear.
    typedef enum logic [2:0] {
        XV_IDLE  = 3'd0,
        XV_FETCH = 3'd1,
        XV_ISSUE = 3'd2,
        XV_RUN   = 3'd3,
        XV_CLEAR = 3'd4
    } xvu_state_e;

    localparam int unsigned XVU_TBL_W = 16;

endpackage

// File: rtl/xvu_arbiter.sv
// Fixed-priority picker: the lowest set index of req wins.
// Assumes N >= 1. The outputs are purely combinational.
module xvu_arbiter #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            // Mark a request as blocked when any lower index is pending.
            assign seen[g+1] = seen[g] | req[g];
            assign grant[g]  = req[g] & ~seen[g];
        end
    endgenerate

    // Encode the single granted bit into an index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) idx = idx | IW'(k);
        end
    end

    assign any = seen[N];

endmodule

// File: rtl/xvu_vec_addr.sv
// Forms a vector-table address: base plus the number shifted left by one.
// Assumes the shifted number fits in 16 bits.
module xvu_vec_addr #(
    parameter int                    IW   = 7,
    parameter logic [15:0]           BASE = 16'h0400
) (
    input  logic [IW-1:0] num,
    output logic [15:0]   addr
);
    // Each table entry is two bytes wide.
    assign addr = BASE + (16'(num) << 1);

endmodule

// File: rtl/xvu_sw_reg.sv
// Software activation register: a vector number and a request bit.
// The request bit clears itself once its vector entry has been read.
// A write in the same cycle wins over the self-clear.
module xvu_sw_reg #(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [VW-1:0] wr_vec,
    input  logic          wr_req,
    input  logic          fetched,
    output logic          pending,
    output logic [VW-1:0] vec
);
    // Hold the register and apply the write or the self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            vec     <= '0;
        end else if (wr) begin
            pending <= wr_req;
            vec     <= wr_vec;
        end else if (fetched) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/xvu_seq.sv
// Activation sequencer. It latches the chosen activation, reads its
// vector entry, checks the alignment, starts the engine and issues the clear.
// Assumes mem_ready is asserted only while mem_req is high, and eng_done
// only in the run state.
module xvu_seq
    import xvu_pkg::*;
#(
    parameter int                  NUM_SRC    = 8,
    parameter int                  IW         = 3,
    parameter int                  ADDR_W     = 24,
    parameter logic [ADDR_W-17:0]  RAM_PREFIX = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hw_any,
    input  logic [IW-1:0]      hw_idx,
    input  logic [15:0]        hw_vaddr,
    input  logic               sw_pend,
    input  logic [15:0]        sw_vaddr,
    input  logic [NUM_SRC-1:0] clr_sel,
    output logic               sw_fetched,
    output logic               mem_req,
    output logic [15:0]        mem_addr,
    input  logic               mem_ready,
    input  logic [15:0]        mem_rdata,
    output logic               eng_start,
    output logic [ADDR_W-1:0]  eng_addr,
    input  logic               eng_done,
    output logic               align_err,
    output logic [NUM_SRC-1:0] flag_clr,
    output logic [NUM_SRC-1:0] en_clr
);
    xvu_state_e         state;
    logic [IW-1:0]      idx_q;
    logic               sw_q;
    logic [15:0]        addr_q;
    logic [15:0]        ptr_q;
    logic               clrsel_q;
    logic               aligned;
    logic [NUM_SRC-1:0] idx_dec;

    // Advance through one activation at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= XV_IDLE;
            idx_q    <= '0;
            sw_q     <= 1'b0;
            addr_q   <= '0;
            ptr_q    <= '0;
            clrsel_q <= 1'b0;
        end else begin
            case (state)
                XV_IDLE: begin
                    if (hw_any) begin
                        idx_q  <= hw_idx;
                        sw_q   <= 1'b0;
                        addr_q <= hw_vaddr;
                        state  <= XV_FETCH;
                    end else if (sw_pend) begin
                        sw_q   <= 1'b1;
                        addr_q <= sw_vaddr;
                        state  <= XV_FETCH;
                    end
                end
                XV_FETCH: begin
                    if (mem_ready) begin
                        ptr_q <= mem_rdata;
                        state <= XV_ISSUE;
                    end
                end
                XV_ISSUE: begin
                    state <= aligned ? XV_RUN : XV_IDLE;
                end
                XV_RUN: begin
                    if (eng_done) begin
                        clrsel_q <= clr_sel[idx_q];
                        state    <= XV_CLEAR;
                    end
                end
                default: begin
                    state <= XV_IDLE;
                end
            endcase
        end
    end

    assign aligned = (ptr_q[1:0] == 2'b00);

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_dec
            // Turn the latched source index into a one-hot clear vector.
            assign idx_dec[g] = (idx_q == IW'(g));
        end
    endgenerate

    // Drive the outputs from the state and the latched activation.
    always_comb begin
        mem_req    = (state == XV_FETCH);
        mem_addr   = addr_q;
        sw_fetched = (state == XV_FETCH) && mem_ready && sw_q;
        eng_start  = (state == XV_ISSUE) && aligned;
        align_err  = (state == XV_ISSUE) && !aligned;
        eng_addr   = {RAM_PREFIX, ptr_q};
        flag_clr   = '0;
        en_clr     = '0;
        if (state == XV_CLEAR && !sw_q) begin
            if (clrsel_q) en_clr   = idx_dec;
            else          flag_clr = idx_dec;
        end
    end

endmodule

// File: rtl/xfer_vector_unit.sv
// Top of the activation vector unit. It routes requests to the transfer
// path or to the CPU, picks one activation, reads its vector entry and
// hands the descriptor address to the engine.
// Assumes NUM_SRC <= 128, so that every table address fits in 16 bits.
module xfer_vector_unit
    import xvu_pkg::*;
#(
    parameter int                  NUM_SRC    = 8,
    parameter int                  ADDR_W     = 24,
    parameter logic [ADDR_W-17:0]  RAM_PREFIX = '1,
    parameter logic [15:0]         VEC_BASE   = 16'h0400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] clr_sel,
    input  logic               sw_wr,
    input  logic [6:0]         sw_wr_vec,
    input  logic               sw_wr_req,
    output logic               sw_pending,
    output logic [NUM_SRC-1:0] cpu_irq,
    output logic               mem_req,
    output logic [15:0]        mem_addr,
    input  logic               mem_ready,
    input  logic [15:0]        mem_rdata,
    output logic               eng_start,
    output logic [ADDR_W-1:0]  eng_addr,
    input  logic               eng_done,
    output logic               align_err,
    output logic [NUM_SRC-1:0] flag_clr,
    output logic [NUM_SRC-1:0] en_clr
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int VW = 7;

    logic          hw_any;
    logic [IW-1:0] hw_idx;
    logic [15:0]   hw_vaddr;
    logic [15:0]   sw_vaddr;
    logic [VW-1:0] sw_vec;
    logic          sw_fetched;

    // Forward the sources that are not enabled to the CPU, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= '0;
        else        cpu_irq <= src_req & ~src_en;
    end

    xvu_arbiter #(.N(NUM_SRC), .IW(IW)) u_arb (
        .req (src_req & src_en),
        .any (hw_any),
        .idx (hw_idx)
    );

    xvu_vec_addr #(.IW(IW), .BASE(VEC_BASE)) u_hw_va (
        .num  (hw_idx),
        .addr (hw_vaddr)
    );

    xvu_vec_addr #(.IW(VW), .BASE(VEC_BASE)) u_sw_va (
        .num  (sw_vec),
        .addr (sw_vaddr)
    );

    xvu_sw_reg #(.VW(VW)) u_swr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (sw_wr),
        .wr_vec  (sw_wr_vec),
        .wr_req  (sw_wr_req),
        .fetched (sw_fetched),
        .pending (sw_pending),
        .vec     (sw_vec)
    );

    xvu_seq #(
        .NUM_SRC    (NUM_SRC),
        .IW         (IW),
        .ADDR_W     (ADDR_W),
        .RAM_PREFIX (RAM_PREFIX)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_any     (hw_any),
        .hw_idx     (hw_idx),
        .hw_vaddr   (hw_vaddr),
        .sw_pend    (sw_pending),
        .sw_vaddr   (sw_vaddr),
        .clr_sel    (clr_sel),
        .sw_fetched (sw_fetched),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .eng_start  (eng_start),
        .eng_addr   (eng_addr),
        .eng_done   (eng_done),
        .align_err  (align_err),
        .flag_clr   (flag_clr),
        .en_clr     (en_clr)
    );

endmodule

// File: rtl/xvu_checker.sv
// Protocol and ordering checks for xfer_vector_unit, attached by bind.
// Assumes the memory side answers only while mem_req is high.
module xvu_checker #(
    parameter int                  NUM_SRC    = 8,
    parameter int                  ADDR_W     = 24,
    parameter logic [ADDR_W-17:0]  RAM_PREFIX = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] cpu_irq,
    input logic               sw_wr,
    input logic               sw_pending,
    input logic               mem_req,
    input logic [15:0]        mem_addr,
    input logic               mem_ready,
    input logic [15:0]        mem_rdata,
    input logic               eng_start,
    input logic [ADDR_W-1:0]  eng_addr,
    input logic               align_err,
    input logic [NUM_SRC-1:0] flag_clr,
    input logic [NUM_SRC-1:0] en_clr
);
    // R1: an enabled source is never forwarded to the CPU.
    assert_enabled_not_forwarded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cpu_irq & $past(src_en)) == '0));

    // R3, R4: table reads stay inside the two-byte-entry table window.
    assert_table_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[15:8] == 8'h04 && !mem_addr[0]));

    // R5: a pending read holds its address.
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R5: only one read in flight.
    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req);

    // R6: an aligned entry starts the engine at the prefixed address.
    assert_start_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_rdata[1:0] == 2'b00) |=>
        (eng_start && !align_err && eng_addr == {RAM_PREFIX, $past(mem_rdata)}));

    // R7: a misaligned entry flags an error instead of a start.
    assert_misaligned_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_rdata[1:0] != 2'b00) |=> (align_err && !eng_start));

    // R8: at most one clear pulse, never to both targets.
    assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr | en_clr) && ((flag_clr & en_clr) == '0));

    // R9: the software request only drops after a read or a write.
    assert_sw_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_pending) |-> ($past(mem_ready) || $past(sw_wr)));

endmodule

bind xfer_vector_unit xvu_checker #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .RAM_PREFIX (RAM_PREFIX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .cpu_irq    (cpu_irq),
    .sw_wr      (sw_wr),
    .sw_pending (sw_pending),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .eng_start  (eng_start),
    .eng_addr   (eng_addr),
    .align_err  (align_err),
    .flag_clr   (flag_clr),
    .en_clr     (en_clr)
);

// File: tb/xfer_vector_unit_tb.sv
// Bench: peripheral, memory and engine responders, a behavioural
// reference model compared on every clock, and directed checks.
module xfer_vector_unit_tb;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req = '0;
    logic [NS-1:0] src_en = '0;
    logic [NS-1:0] clr_sel = '0;
    logic          sw_wr = 1'b0;
    logic [6:0]    sw_wr_vec = '0;
    logic          sw_wr_req = 1'b0;
    logic          sw_pending;
    logic [NS-1:0] cpu_irq;
    logic          mem_req;
    logic [15:0]   mem_addr;
    logic          mem_ready = 1'b0;
    logic [15:0]   mem_rdata = '0;
    logic          eng_start;
    logic [23:0]   eng_addr;
    logic          eng_done = 1'b0;
    logic          align_err;
    logic [NS-1:0] flag_clr;
    logic [NS-1:0] en_clr;

    // Stimulus controls
    logic [NS-1:0] set_req = '0;
    logic          en_ld = 1'b0;
    logic [NS-1:0] en_val = '0;
    logic [15:0]   bad_addr = 16'h0000;
    int            mem_wait = 0;
    int            eng_lat = 1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    xfer_vector_unit u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .clr_sel(clr_sel), .sw_wr(sw_wr), .sw_wr_vec(sw_wr_vec),
        .sw_wr_req(sw_wr_req), .sw_pending(sw_pending), .cpu_irq(cpu_irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .eng_start(eng_start), .eng_addr(eng_addr),
        .eng_done(eng_done), .align_err(align_err), .flag_clr(flag_clr),
        .en_clr(en_clr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] tbl(input logic [15:0] a);
        logic [15:0] v;
        v = 16'h8000 + ((a - 16'h0400) << 2);
        if (a == bad_addr) v = v | 16'h0002;
        return v;
    endfunction

    // Peripheral flags and enable register
    always @(posedge clk) begin
        if (!rst_n) begin
            src_req <= '0;
            src_en  <= '0;
        end else begin
            src_req <= (src_req & ~flag_clr) | set_req;
            src_en  <= en_ld ? en_val : (src_en & ~en_clr);
        end
    end

    // Memory responder with wait states
    int wcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt >= mem_wait) begin
                mem_ready = 1'b1;
                mem_rdata = tbl(mem_addr);
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    // Engine responder
    int ecnt = 0;
    always @(negedge clk) begin
        eng_done = 1'b0;
        if (!rst_n) ecnt = 0;
        else if (eng_start) ecnt = eng_lat + 1;
        else if (ecnt > 0) begin
            ecnt--;
            if (ecnt == 0) eng_done = 1'b1;
        end
    end

    // Reference model
    int            m_st = 0;
    int            m_idx = 0;
    bit            m_sw = 0;
    int            m_addr = 0;
    logic [15:0]   m_ptr = '0;
    bit            m_swp = 0;
    int            m_swvec = 0;
    logic [NS-1:0] m_cpu = '0;
    bit            m_csel = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st <= 0; m_swp <= 0; m_swvec <= 0; m_cpu <= '0; m_sw <= 0;
        end else begin
            logic [NS-1:0] act;
            int sel;
            m_cpu <= src_req & ~src_en;
            if (sw_wr) begin
                m_swp <= sw_wr_req;
                m_swvec <= int'(sw_wr_vec);
            end else if (m_st == 1 && mem_ready && m_sw) begin
                m_swp <= 0;
            end
            act = src_req & src_en;
            sel = -1;
            for (int i = NS - 1; i >= 0; i--) if (act[i]) sel = i;
            case (m_st)
                0: if (sel >= 0) begin
                       m_idx <= sel; m_sw <= 0; m_addr <= 1024 + 2 * sel; m_st <= 1;
                   end else if (m_swp) begin
                       m_sw <= 1; m_addr <= 1024 + 2 * m_swvec; m_st <= 1;
                   end
                1: if (mem_ready) begin m_ptr <= mem_rdata; m_st <= 2; end
                2: m_st <= (m_ptr[1:0] == 2'b00) ? 3 : 0;
                3: if (eng_done) begin m_csel <= clr_sel[m_idx]; m_st <= 4; end
                default: m_st <= 0;
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NS-1:0] efc, eec;
            bit es, ea;
            efc = '0; eec = '0;
            if (m_st == 4 && !m_sw) begin
                if (m_csel) eec[m_idx] = 1'b1; else efc[m_idx] = 1'b1;
            end
            es = (m_st == 2) && (m_ptr[1:0] == 2'b00);
            ea = (m_st == 2) && (m_ptr[1:0] != 2'b00);
            chk(mem_req == (m_st == 1), "R5 mem_req", mem_req, m_st == 1);
            if (mem_req && m_st == 1)
                chk(mem_addr == 16'(m_addr), m_sw ? "R4 sw addr" : "R3 hw addr", mem_addr, m_addr);
            chk(eng_start == es, "R6 eng_start", eng_start, es);
            if (es) chk(eng_addr == {8'hFF, m_ptr}, "R6 eng_addr", eng_addr, {8'hFF, m_ptr});
            chk(align_err == ea, "R7 align_err", align_err, ea);
            chk(flag_clr == efc, "R8 flag_clr", flag_clr, efc);
            chk(en_clr == eec, "R8 en_clr", en_clr, eec);
            chk(sw_pending == m_swp, "R9 sw_pending", sw_pending, m_swp);
            chk(cpu_irq == m_cpu, "R1 cpu_irq", cpu_irq, m_cpu);
        end
    end

    task automatic raise(input logic [NS-1:0] m);
        @(negedge clk); set_req = m;
        @(negedge clk); set_req = '0;
    endtask

    task automatic sw_write(input logic [6:0] v, input logic r);
        @(negedge clk); sw_wr = 1'b1; sw_wr_vec = v; sw_wr_req = r;
        @(negedge clk); sw_wr = 1'b0;
    endtask

    task automatic load_en(input logic [NS-1:0] v);
        @(negedge clk); en_ld = 1'b1; en_val = v;
        @(negedge clk); en_ld = 1'b0;
    endtask

    task automatic wait_fetch(input logic [15:0] exp, input string tag);
        for (int k = 0; k < 100 && mem_req; k++) @(negedge clk);
        for (int k = 0; k < 100 && !mem_req; k++) @(negedge clk);
        chk(mem_req && mem_addr == exp, tag, mem_addr, exp);
    endtask

    initial begin
        // Watchdog
        wait (cycles >= 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, 20000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({mem_req, eng_start, align_err, sw_pending} == 4'b0 && cpu_irq == '0
            && flag_clr == '0 && en_clr == '0, "R11 in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !sw_pending && cpu_irq == '0, "R11 after reset", mem_req, 0);

        clr_sel = 8'h04;
        load_en(8'h7F);

        // R2 and R3: two sources at once, lower index first
        raise(8'b0000_1010);
        wait_fetch(16'h0402, "R2 lowest index first");
        wait_fetch(16'h0406, "R3 source 3 address");
        repeat (10) @(negedge clk);
        chk(src_req == '0, "R8 flags cleared", src_req, 0);

        // R4 and R9: software activation
        sw_write(7'h10, 1'b1);
        wait_fetch(16'h0420, "R4 vector 0x10");
        repeat (10) @(negedge clk);
        chk(sw_pending == 1'b0, "R9 self-clear", sw_pending, 0);

        // R2: hardware beats software
        @(negedge clk);
        sw_wr = 1'b1; sw_wr_vec = 7'h05; sw_wr_req = 1'b1; set_req = 8'h01;
        @(negedge clk);
        sw_wr = 1'b0; set_req = '0;
        wait_fetch(16'h0400, "R2 hardware over software");
        wait_fetch(16'h040A, "R4 vector 0x05");
        repeat (10) @(negedge clk);

        // R1: disabled source goes to the CPU, not to the engine
        raise(8'h80);
        repeat (5) @(negedge clk);
        chk(cpu_irq == 8'h80, "R1 disabled forwarded", cpu_irq, 8'h80);
        chk(!mem_req, "R1 no fetch for disabled", mem_req, 0);

        // R8: enable-bit clear on source 2
        raise(8'h04);
        wait_fetch(16'h0404, "R3 source 2 address");
        repeat (10) @(negedge clk);
        chk(src_en[2] == 1'b0 && src_req[2] == 1'b1, "R8 enable cleared, flag kept",
            {src_en[2], src_req[2]}, 2'b01);
        chk(cpu_irq == 8'h84, "R1 now routed to CPU", cpu_irq, 8'h84);

        // R7: misaligned entry for source 4
        bad_addr = 16'h0408;
        raise(8'h10);
        repeat (12) @(negedge clk);
        chk(src_req[4] == 1'b1, "R7 no clear after error", src_req[4], 1);
        bad_addr = 16'h0000;
        repeat (12) @(negedge clk);
        chk(src_req[4] == 1'b0, "R7 serviced once aligned", src_req[4], 0);

        // R5 and R10: wait states, requests arriving while busy
        mem_wait = 3;
        eng_lat = 4;
        raise(8'h02);
        wait_fetch(16'h0402, "R5 fetch with wait states");
        raise(8'h20);
        sw_write(7'h7F, 1'b1);
        raise(8'h01);
        wait_fetch(16'h0400, "R10 held request by priority");
        wait_fetch(16'h040A, "R10 second held request");
        wait_fetch(16'h04FE, "R4 vector 0x7F");
        repeat (20) @(negedge clk);
        chk(src_req == 8'h84, "R10 all held requests served", src_req, 8'h84);
        chk(!sw_pending, "R9 final", sw_pending, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule